// File: doc/BRIEF.md
# Supply Monitor Control and Status Register

This block is the register-side companion of an analog brown-out monitor. It holds the monitor's enable and threshold-select bits and drives them out to the analog circuit. It takes the comparator's one-bit "supply is safe" verdict back in and synchronizes it into the clock domain. It then shows that verdict as a read-only status bit. The status bit is forced to "safe" while the monitor is switched off.

A falling edge of the qualified status marks a low-supply event. The event sets a sticky flag. Software removes the flag by writing a 1 to it, and the clear only takes effect once the supply has come back. So the flag cannot be dismissed while the brown-out condition is still present. Two enable inputs gate the flag onto separate normal and fast interrupt request lines. The register sits at one parameterized address on a simple synchronous bus with combinational read data.

Top module: `supply_mon_csr`

## Requirements
- R1: After a synchronous active-low reset the register reads 0x8: bit 3 = 1, bits 2..0 = 0. `mon_enable`, `mon_trip_hi`, `irq_req` and `fiq_req` are all low.
- R2: A write to the register address loads bit 1 (monitor on) and bit 2 (high threshold when 1, low when 0). Both bits read back and appear on `mon_enable` and `mon_trip_hi` after the write edge. Write data bit 3 is ignored.
- R3: While bit 1 is set, bit 3 reads the comparator input delayed by a two-flop synchronizer: it changes after the second clock edge that follows a change of `cmp_ok`. While bit 1 is clear, bit 3 reads 1 whatever `cmp_ok` is.
- R4: Bit 0 (low-supply flag) is set one edge after bit 3 falls from 1 to 0. This gives three edges after `cmp_ok` drops with the monitor on, or one edge after a write that turns the monitor on while `cmp_ok` is already low.
- R5: Writing 1 to bit 0 clears the flag at that write's edge when bit 3 reads 1 just before that edge. This includes the first cycle in which bit 3 has returned high.
- R6: Writing 1 to bit 0 while bit 3 reads 0 is ignored, and the flag stays set.
- R7: Writing 0 to bit 0 leaves the flag unchanged.
- R8: `irq_req` equals the flag ANDed with `irq_en`. `fiq_req` equals the flag ANDed with `fiq_en`.
- R9: A write to any other address changes nothing. A read of any other address returns 0.
- R10: Turning the monitor off does not set the flag, and it does not clear a flag that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (4) | Write data |
| bus_rdata | output | DATA_W (4) | Read data, combinational on address |
| cmp_ok | input | 1 | Asynchronous comparator verdict, 1 = supply above threshold |
| irq_en | input | 1 | Normal interrupt enable |
| fiq_en | input | 1 | Fast interrupt enable |
| mon_enable | output | 1 | Power-on for the analog monitor |
| mon_trip_hi | output | 1 | Threshold select for the analog monitor |
| irq_req | output | 1 | Normal interrupt request |
| fiq_req | output | 1 | Fast interrupt request |

## Verification
All four combinations of the enable and threshold bits are written, with bit 3 of the write data also toggled, to show that the control bits are stored independently and that the status bit cannot be written. The comparator is dropped and raised with the monitor on, and the status and flag are sampled edge by edge, which pins down the synchronizer depth and the one-edge flag latency. Clear writes are placed one cycle before and exactly on the first safe cycle, which tells a correctly gated clear from one that is too eager or too late. Turning the monitor on and off with the comparator low separates the enable-qualified edge from the raw one, and a sweep of both interrupt enables against set and clear flags covers the request gating.

// File: rtl/supmon_pkg.sv
// Package: shared field positions and widths for the supply monitor register.
// Assumes a register of at least four bits; the positions matter to software.
package supmon_pkg;
    localparam int FLD_FLAG = 0;   // sticky low-supply flag, write-1-to-clear
    localparam int FLD_EN   = 1;   // monitor power-on
    localparam int FLD_TRIP = 2;   // threshold select
    localparam int FLD_STAT = 3;   // synchronized safe status, read-only
    localparam int REG_BITS = 4;
endpackage

// File: rtl/supmon_sync.sv
// Module: multi-flop synchronizer for the comparator verdict.
// Assumes STAGES >= 2; resets to the "safe" level so that reset produces no event.
module supmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/supmon_flag.sv
// Module: sticky low-supply flag with falling-edge set and gated write-1 clear.
// Assumes status is already synchronous and enable-qualified (1 = safe).
module supmon_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic status,
    input  logic clr_req,
    output logic flag
);
    logic status_q;
    logic fall;
    logic flag_q;

    // Remember last cycle's status for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= 1'b1;
        else        status_q <= status;
    end

    assign fall = status_q & ~status;

    // Set on a falling edge, clear only while safe; a set outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (fall)               flag_q <= 1'b1;
        else if (clr_req && status)  flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R4: a detected fall sets the flag on the next edge.
    a_r4_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> flag_q);
    // R6: a clear while unsafe does not drop the flag.
    a_r6_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && clr_req && !status) |=> flag_q);
    // R5: a clear while safe takes effect at once.
    a_r5_clear_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && clr_req && status && !fall) |=> !flag_q);
    // R10: a rising status never sets the flag.
    a_r10_rise_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && status) |=> !flag_q);
endmodule

// File: rtl/supply_mon_csr.sv
// Module: control/status register for an analog brown-out monitor.
// Decodes one address, drives enable/threshold to the analog side, synchronizes
// the comparator verdict and raises gated interrupt requests from a sticky flag.
// Assumes a single-cycle write strobe and combinational reads.
module supply_mon_csr
    import supmon_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = REG_BITS,
    parameter logic [7:0]  REG_ADDR    = 8'h40,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmp_ok,
    input  logic              irq_en,
    input  logic              fiq_en,
    output logic              mon_enable,
    output logic              mon_trip_hi,
    output logic              irq_req,
    output logic              fiq_req
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    logic hit;
    logic wr_hit;
    logic en_q;
    logic trip_q;
    logic cmp_sync;
    logic status;
    logic flag;

    assign hit    = (bus_addr == HIT_ADDR);
    assign wr_hit = hit & bus_wr;

    // Load the control fields on a write to this register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            trip_q <= 1'b0;
        end else if (wr_hit) begin
            en_q   <= bus_wdata[FLD_EN];
            trip_q <= bus_wdata[FLD_TRIP];
        end
    end

    supmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_ok),
        .q     (cmp_sync)
    );

    assign status = cmp_sync | ~en_q;

    supmon_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .status  (status),
        .clr_req (wr_hit & bus_wdata[FLD_FLAG]),
        .flag    (flag)
    );

    // Assemble read data for this address, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata[FLD_FLAG] = flag;
            bus_rdata[FLD_EN]   = en_q;
            bus_rdata[FLD_TRIP] = trip_q;
            bus_rdata[FLD_STAT] = status;
        end
    end

    assign mon_enable  = en_q;
    assign mon_trip_hi = trip_q;
    assign irq_req     = flag & irq_en;
    assign fiq_req     = flag & fiq_en;

    // R1: reset leaves control and flag low.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!mon_enable && !mon_trip_hi && !irq_req && !fiq_req));
    // R8: no request without its enable.
    a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_req);
    a_r8_fiq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_en |-> !fiq_req);
    // R9: writes elsewhere leave the control outputs alone.
    a_r9_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> ($stable(mon_enable) && $stable(mon_trip_hi)));
endmodule

// File: tb/supply_mon_csr_bench.sv
module supply_mon_csr_bench;
    localparam logic [7:0] RA = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = RA;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       cmp_ok = 1'b1;
    logic       irq_en = 1'b0;
    logic       fiq_en = 1'b0;
    logic       mon_enable, mon_trip_hi, irq_req, fiq_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    supply_mon_csr u_supply_mon_csr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_ok(cmp_ok),
        .irq_en(irq_en), .fiq_en(fiq_en), .mon_enable(mon_enable),
        .mon_trip_hi(mon_trip_hi), .irq_req(irq_req), .fiq_req(fiq_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = RA;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input int exp);
        bus_addr = a;
        #0.5;
        chk(tag, int'(bus_rdata), exp);
        bus_addr = RA;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1
        rd("R1 reset value", RA, 4'h8);
        chk("R1 outputs", {mon_enable, mon_trip_hi, irq_req, fiq_req}, 0);

        // R2: every enable/threshold pair, bit 3 of write data toggled
        for (int i = 0; i < 8; i++) begin
            logic [3:0] d;
            d = {i[2], i[1], i[0], 1'b0};
            wr(RA, d);
            rd("R2 readback", RA, {1'b1, d[2], d[1], 1'b0});
            chk("R2 outputs", {mon_trip_hi, mon_enable}, {d[2], d[1]});
        end

        // R3/R10: disabled, comparator low, status stays safe, no flag
        wr(RA, 4'h0);
        cmp_ok = 1'b0;
        step(4);
        rd("R3 disabled reads safe", RA, 4'h8);

        // R4: enabling with comparator low sets flag one edge later
        wr(RA, 4'h2);
        rd("R4 status low, flag not yet", RA, 4'h2);
        step(1);
        rd("R4 flag set after enable", RA, 4'h3);

        // R6 and R7
        wr(RA, 4'h3);
        rd("R6 clear while low ignored", RA, 4'h3);
        wr(RA, 4'h2);
        rd("R7 zero write keeps flag", RA, 4'h3);

        // R8: enable sweep with flag set
        for (int i = 0; i < 4; i++) begin
            irq_en = i[0]; fiq_en = i[1];
            #0.5;
            chk("R8 set flag irq", irq_req, i[0]);
            chk("R8 set flag fiq", fiq_req, i[1]);
        end

        // R3: two-edge synchronizer latency on recovery
        cmp_ok = 1'b1;
        step(1);
        rd("R3 status after one edge", RA, 4'h3);
        step(1);
        rd("R3 status after two edges", RA, 4'hB);
        wr(RA, 4'h3);
        rd("R5 clear while safe", RA, 4'hA);
        chk("R8 cleared flag irq", irq_req, 0);
        chk("R8 cleared flag fiq", fiq_req, 0);

        // R4: three-edge latency from comparator drop
        cmp_ok = 1'b0;
        step(2);
        rd("R4 status low, flag pending", RA, 4'h2);
        step(1);
        rd("R4 flag after three edges", RA, 4'h3);

        // R10: disable keeps flag, status safe; then clear works
        wr(RA, 4'h0);
        rd("R10 disable keeps flag", RA, 4'h9);
        wr(RA, 4'h1);
        rd("R5 clear while disabled", RA, 4'h8);

        // R9
        wr(RA + 8'h1, 4'h7);
        rd("R9 other write ignored", RA, 4'h8);
        rd("R9 other read zero", RA + 8'h1, 4'h0);
        chk("R9 outputs unchanged", {mon_enable, mon_trip_hi}, 0);

        // R5/R6: clear one cycle early is ignored, on first safe cycle succeeds
        wr(RA, 4'h2);
        step(1);
        rd("R4 re-enable sets flag", RA, 4'h3);
        cmp_ok = 1'b1;
        step(1);
        wr(RA, 4'h3);
        rd("R6 early clear ignored", RA, 4'hB);
        wr(RA, 4'h3);
        rd("R5 clear later", RA, 4'hA);
        cmp_ok = 1'b0;
        step(3);
        rd("R4 flag again", RA, 4'h3);
        cmp_ok = 1'b1;
        step(2);
        wr(RA, 4'h3);
        rd("R5 clear on first safe cycle", RA, 4'hA);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule